// File: doc/BRIEF.md
# Parcel Stream Instruction Length Splitter

This block sits between an instruction fetch buffer and the decoder of a processor whose instructions are either one or two 16-bit parcels long. The stream carries no marker of where an instruction begins, so the block finds each boundary by looking at the leading opcode bits of the parcel that starts the next instruction. It then hands one whole instruction at a time downstream, in a 32-bit word with a length tag.

The block uses a fixed split of the opcode space. A clear top bit covers half of it and means a one-parcel instruction. Top nibbles 1000 to 1110 cover seven sixteenths and mean a two-parcel instruction. The all-ones top nibble, the last sixteenth, marks a one-parcel prefix. After a prefix, the length rule for what follows is not known to this block. It therefore passes each later parcel through raw, with a marker, until the downstream logic acknowledges the prefix.

Parcels come in and instructions go out over valid/ready handshakes. A flush input drops any half-built instruction, any pending prefix and the output word.

Top module: `parcel_len_splitter`

## Requirements
- R1: After a synchronous reset with flush low, `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted parcel whose bit 15 is 0, taken with no prefix pending and no half instruction held, is emitted alone. `out_len32`, `out_raw` and `out_prefix` are 0, `out_data[15:0]` is the parcel and `out_data[31:16]` is 0.
- R3: An accepted parcel whose bits 15:12 are 1000 to 1110, taken with no prefix pending, emits nothing on its own. The next accepted parcel completes the instruction, which is emitted with `out_len32`=1, the first parcel in `out_data[31:16]` and the second in `out_data[15:0]`, whatever the second parcel's bits.
- R4: An accepted parcel whose bits 15:12 are 1111, taken with no prefix pending and no half instruction held, is emitted as a one-parcel word with `out_prefix`=1 and `out_raw`=0, and it makes a prefix pending.
- R5: While a prefix is pending, every accepted parcel is emitted as a one-parcel word with `out_raw`=1 and `out_prefix`=0, whatever its top bits are.
- R6: `prefix_ack` high at a clock edge ends a pending prefix from the next cycle on. A parcel accepted at that same edge is still emitted raw. An ack at the edge where a prefix is accepted does not cancel the new prefix.
- R7: While `flush` is high, `in_ready` is 0. The cycle after a flush, `out_valid` is 0, no half instruction is held and no prefix is pending.
- R8: `in_ready` equals NOT `flush` AND (NOT `out_valid` OR `out_ready`). While `out_valid` is high and `out_ready` is low (and there is no flush), the output word and its tags stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pipeline flush, drops all partial state |
| prefix_ack | input | 1 | Downstream acknowledge ending prefix pass-through |
| in_valid | input | 1 | Parcel valid |
| in_ready | output | 1 | Parcel accepted when high with in_valid |
| in_parcel | input | 16 | Parcel from the fetch buffer |
| out_valid | output | 1 | Instruction word valid |
| out_ready | input | 1 | Downstream can take the word |
| out_data | output | 32 | Instruction; one-parcel forms in the low half |
| out_len32 | output | 1 | Word holds a two-parcel instruction |
| out_raw | output | 1 | Parcel passed through under a pending prefix |
| out_prefix | output | 1 | Word is a prefix parcel |

## Verification
The bench builds the block with its defaults: 16-bit parcels and a 4-bit class tag. With a 4-bit tag, a one-in-sixteen share of random parcels is a prefix. A mostly random parcel stream therefore reaches prefix pass-through, acks that land during raw output, and two-parcel instructions whose second half looks like a prefix, all many times within a few thousand cycles. Random output backpressure and occasional flushes then exercise stalls and drops mid-instruction and mid-prefix.

// File: rtl/pls_pkg.sv
package pls_pkg;
  typedef enum logic [1:0] {
    CLS_SHORT  = 2'd0,
    CLS_HEAD   = 2'd1,
    CLS_PREFIX = 2'd2
  } cls_e;
endpackage

// File: rtl/pls_classify.sv
// Parcel class from the leading opcode bits.
module pls_classify
  import pls_pkg::*;
#(
  parameter int PW   = 16,
  parameter int TAGW = 4
) (
  input  logic [PW-1:0] parcel,
  output cls_e          cls
);
  localparam logic [TAGW-1:0] TAG_ALL = {TAGW{1'b1}};

  always_comb begin
    if (!parcel[PW-1])                     cls = CLS_SHORT;
    else if (parcel[PW-1 -: TAGW] == TAG_ALL) cls = CLS_PREFIX;
    else                                   cls = CLS_HEAD;
  end
endmodule

// File: rtl/pls_track.sv
// Holds the first half of a long instruction and the prefix-pending flag,
// and forms the word to emit for each accepted parcel.
module pls_track
  import pls_pkg::*;
#(
  parameter int PW = 16,
  localparam int IW = 2 * PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          ack,
  input  logic          take,
  input  logic [PW-1:0] parcel,
  input  cls_e          cls,
  output logic          emit,
  output logic [IW-1:0] e_data,
  output logic          e_len32,
  output logic          e_raw,
  output logic          e_pfx
);
  logic          half_q;
  logic          pend_q;
  logic [PW-1:0] hi_q;

  always_comb begin
    emit    = 1'b0;
    e_data  = {{PW{1'b0}}, parcel};
    e_len32 = 1'b0;
    e_raw   = 1'b0;
    e_pfx   = 1'b0;
    if (take) begin
      if (pend_q) begin
        emit  = 1'b1;
        e_raw = 1'b1;
      end else if (half_q) begin
        emit    = 1'b1;
        e_len32 = 1'b1;
        e_data  = {hi_q, parcel};
      end else begin
        unique case (cls)
          CLS_SHORT:  emit = 1'b1;
          CLS_PREFIX: begin
            emit  = 1'b1;
            e_pfx = 1'b1;
          end
          default:    emit = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      half_q <= 1'b0;
      pend_q <= 1'b0;
      hi_q   <= '0;
    end else begin
      if (take && !pend_q) begin
        if (half_q) begin
          half_q <= 1'b0;
        end else if (cls == CLS_HEAD) begin
          half_q <= 1'b1;
          hi_q   <= parcel;
        end
      end
      if (take && !pend_q && !half_q && cls == CLS_PREFIX) pend_q <= 1'b1;
      else if (ack)                                        pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pls_outreg.sv
// Registered output stage with hold under backpressure.
module pls_outreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         load,
  input  logic [W-1:0] d_data,
  input  logic         d_len32,
  input  logic         d_raw,
  input  logic         d_pfx,
  input  logic         o_ready,
  output logic         free,
  output logic         o_valid,
  output logic [W-1:0] o_data,
  output logic         o_len32,
  output logic         o_raw,
  output logic         o_pfx
);
  assign free = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_data  <= '0;
      o_len32 <= 1'b0;
      o_raw   <= 1'b0;
      o_pfx   <= 1'b0;
    end else if (flush) begin
      o_valid <= 1'b0;
    end else if (free) begin
      o_valid <= load;
      if (load) begin
        o_data  <= d_data;
        o_len32 <= d_len32;
        o_raw   <= d_raw;
        o_pfx   <= d_pfx;
      end
    end
  end
endmodule

// File: rtl/parcel_len_splitter.sv
module parcel_len_splitter
  import pls_pkg::*;
#(
  parameter int PW   = 16,
  parameter int TAGW = 4,
  localparam int IW  = 2 * PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          prefix_ack,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_parcel,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] out_data,
  output logic          out_len32,
  output logic          out_raw,
  output logic          out_prefix
);
  cls_e          cls;
  logic          free;
  logic          take;
  logic          emit;
  logic [IW-1:0] e_data;
  logic          e_len32, e_raw, e_pfx;

  assign in_ready = !rst && !flush && free;
  assign take     = in_valid && in_ready;

  pls_classify #(.PW(PW), .TAGW(TAGW)) u_cls (
    .parcel (in_parcel),
    .cls    (cls)
  );

  pls_track #(.PW(PW)) u_trk (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .ack     (prefix_ack),
    .take    (take),
    .parcel  (in_parcel),
    .cls     (cls),
    .emit    (emit),
    .e_data  (e_data),
    .e_len32 (e_len32),
    .e_raw   (e_raw),
    .e_pfx   (e_pfx)
  );

  pls_outreg #(.W(IW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .load    (emit),
    .d_data  (e_data),
    .d_len32 (e_len32),
    .d_raw   (e_raw),
    .d_pfx   (e_pfx),
    .o_ready (out_ready),
    .free    (free),
    .o_valid (out_valid),
    .o_data  (out_data),
    .o_len32 (out_len32),
    .o_raw   (out_raw),
    .o_pfx   (out_prefix)
  );
endmodule

// File: rtl/parcel_len_splitter_chk.sv
module parcel_len_splitter_chk #(
  parameter int PW   = 16,
  parameter int TAGW = 4,
  localparam int IW  = 2 * PW
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] out_data,
  input logic          out_len32,
  input logic          out_raw,
  input logic          out_prefix
);
  // R8: word held under backpressure
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_data) && $stable(out_len32));
  // R7: flush empties the output stage
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid);
  // R7: nothing accepted during flush
  a_r7_no_accept: assert property (@(posedge clk) disable iff (rst)
    flush |-> !in_ready);
  // R3: long words start with a head tag
  a_r3_long_head: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_len32 |-> out_data[IW-1] && (out_data[IW-1 -: TAGW] != {TAGW{1'b1}}));
  // R2: one-parcel words keep the upper half clear
  a_r2_short_upper_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_len32 |-> out_data[IW-1:PW] == '0);
  // R4: prefix words carry the all-ones tag and are not raw
  a_r4_prefix_tag: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_prefix |-> (out_data[PW-1 -: TAGW] == {TAGW{1'b1}}) && !out_raw && !out_len32);
endmodule

bind parcel_len_splitter parcel_len_splitter_chk #(.PW(PW), .TAGW(TAGW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_len32  (out_len32),
  .out_raw    (out_raw),
  .out_prefix (out_prefix)
);

// File: tb/parcel_len_splitter_bench.sv
module parcel_len_splitter_bench;
  localparam int PERIOD = 10;
  localparam int NCYC   = 4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        prefix_ack = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_parcel = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_len32, out_raw, out_prefix;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // reference model state
  bit        m_v, m_len, m_raw, m_pfx, m_half, m_pend;
  bit [31:0] m_data;
  bit [15:0] m_hi;

  always #(PERIOD/2) clk = ~clk;

  parcel_len_splitter u_parcel_len_splitter (
    .clk(clk), .rst(rst), .flush(flush), .prefix_ack(prefix_ack),
    .in_valid(in_valid), .in_ready(in_ready), .in_parcel(in_parcel),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_len32(out_len32), .out_raw(out_raw), .out_prefix(out_prefix)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    chk(out_valid === m_v, "R3/R7 out_valid", {31'b0, out_valid}, {31'b0, m_v});
    if (m_v) begin
      chk(out_data === m_data, "R2/R3 out_data", out_data, m_data);
      chk(out_len32 === m_len, "R3 out_len32", {31'b0, out_len32}, {31'b0, m_len});
      chk(out_raw === m_raw, "R5/R6 out_raw", {31'b0, out_raw}, {31'b0, m_raw});
      chk(out_prefix === m_pfx, "R4 out_prefix", {31'b0, out_prefix}, {31'b0, m_pfx});
    end
  endtask

  function automatic logic [15:0] pick_parcel();
    int r;
    logic [15:0] p;
    r = $urandom % 16;
    p = 16'($urandom);
    if (r < 8)       p[15]    = 1'b0;
    else if (r < 15) p[15:12] = 4'(8 + ($urandom % 7));
    else             p[15:12] = 4'hF;
    return p;
  endfunction

  initial begin
    bit exp_ready, take, emit, e_len, e_raw, e_pfx, free;
    bit [31:0] e_data;
    // reset phase
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(out_valid === 1'b0, "R1 out_valid after reset", {31'b0, out_valid}, 32'd0);
    chk(in_ready === 1'b1, "R1 in_ready after reset", {31'b0, in_ready}, 32'd1);

    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      compare_outputs();
      // new inputs
      in_valid   = ($urandom % 4) != 0;
      in_parcel  = pick_parcel();
      out_ready  = ((c / 200) % 3 == 1) ? (($urandom % 4) == 0) : (($urandom % 10) < 7);
      flush      = ($urandom % 40) == 0;
      prefix_ack = ($urandom % 12) == 0;
      #1;
      exp_ready = !flush && (!m_v || out_ready);
      chk(in_ready === exp_ready, "R8/R7 in_ready", {31'b0, in_ready}, {31'b0, exp_ready});
      // advance model over the coming edge
      take = in_valid && exp_ready;
      emit = 0; e_len = 0; e_raw = 0; e_pfx = 0;
      e_data = {16'h0, in_parcel};
      if (take) begin
        if (m_pend) begin
          emit = 1; e_raw = 1;                       // R5 / R6
        end else if (m_half) begin
          emit = 1; e_len = 1; e_data = {m_hi, in_parcel};  // R3
        end else if (!in_parcel[15]) begin
          emit = 1;                                  // R2
        end else if (in_parcel[15:12] == 4'hF) begin
          emit = 1; e_pfx = 1;                       // R4
        end
      end
      free = !m_v || out_ready;
      if (flush) begin
        m_v = 0; m_half = 0; m_pend = 0;            // R7
      end else begin
        if (free) begin
          m_v = emit;
          if (emit) begin
            m_data = e_data; m_len = e_len; m_raw = e_raw; m_pfx = e_pfx;
          end
        end
        if (take && !m_pend) begin
          if (m_half) m_half = 0;
          else if (in_parcel[15] && in_parcel[15:12] != 4'hF) begin
            m_half = 1; m_hi = in_parcel;
          end
        end
        if (e_pfx) m_pend = 1;
        else if (prefix_ack) m_pend = 0;            // R6
      end
    end
    @(negedge clk);
    compare_outputs();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule